// File: doc/BRIEF.md
# Ethernet MAC Control Register Bank

This block is the software-visible control and status register bank of a simple Ethernet MAC. A host reads and writes 32-bit registers through a single-cycle port. The byte address is turned into a word index. Every implemented register has its own write rule: a plain store, a store through a mask, a store with forced bits, a write-one-to-clear, or a write that also touches other registers. The bank holds the event and interrupt-mask registers and drives one level-sensitive interrupt line from them. DMA engines report events as one-cycle pulses.

The bank also holds the MAC enable and soft-reset controls, the ring-active flags, and the receive and transmit ring start addresses. It drives reload strobes that tell the DMA engines to restart their descriptor pointers from those start addresses. The PHY management frame register starts a request/acknowledge transaction toward a management interface engine. When the transaction finishes, a read result is stored in the register and an event is raised.

Top module: `ethmac_regbank`

## Requirements
- R1: The word index is the byte address shifted right by two. Indices that are not implemented read as zero, and writes to them change no register. The bench probes index 70.
- R2: After reset the bank holds these values, with every other register zero: control (index 9) 0xF0000000, counter control (25) 0xC0000000, receive control (33) 0x05EE0001, pause opcode (59) 0x00010000, receive FIFO bound (83) 0x600, receive FIFO start (84) 0x500, gasket enable (194) 0x6.
- R3: The event register (index 1) is write-one-to-clear. Only bits 31 down to 23 exist; other bits always read zero.
- R4: Event pulses on the input OR into the event register on the next clock edge. A pulse wins over a clear of the same bit in the same cycle.
- R5: The interrupt output is high exactly while the event register ANDed with the mask register (index 2) is nonzero.
- R6: Masked stores: receive control keeps bits 0x07FF003F, management clock divider (17) 0xFE, transmit watermark (81) 0x3, receive buffer limit (98) 0x7F0, gasket config (192) 0x53. The ring start registers (96 receive, 97 transmit) store the value with bits 1..0 cleared.
- R7: Forced stores: FIFO start stores (v & 0x3FC) | 0x400; opcode stores (v & 0xFFFF) | 0x10000; counter control becomes 0xC0000000 when bit 31 is written and 0 otherwise; gasket enable becomes 0x6 when bit 1 is written and 0 otherwise.
- R8: A control write with bit 0 set restores every register to its reset value and discards the written value. Both reload strobes pulse in the next cycle.
- R9: A control write with bit 0 clear stores the value; bit 1 is the MAC enable. If bit 1 is zero, both ring-active flags clear and both reload strobes pulse in the next cycle.
- R10: A write to a ring-active register (4 receive, 5 transmit) while enabled makes it read 0x01000000. While disabled, it reads zero.
- R11: A ring start write pulses that ring's reload strobe in the next cycle, with the new base already on the ring base output.
- R12: Writing transmit control (49) with bit 0 set raises event bit 28. The FIFO bound register ignores writes.
- R13: A management register (16) write raises the request until acknowledge. Bit 29 selects read, bits 27..18 carry the PHY/register address and bits 15..0 the data. On acknowledge, a read deposits the returned 16 bits into bits 15..0, and either kind raises event bit 23. Writes while a request is pending are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W | Byte address for reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr, combinational |
| evtIn | input | 32 | Event pulses from the DMA engines, event bit positions |
| irq | output | 1 | Level interrupt |
| macEnable | output | 1 | MAC enable bit of the control register |
| rxActive | output | 1 | Receive ring active flag |
| txActive | output | 1 | Transmit ring active flag |
| rxRingBase | output | 32 | Receive ring start address |
| txRingBase | output | 32 | Transmit ring start address |
| rxPtrReload | output | 1 | Reload strobe for the receive descriptor pointer |
| txPtrReload | output | 1 | Reload strobe for the transmit descriptor pointer |
| mdioReq | output | 1 | Management transaction request, held until acknowledge |
| mdioRead | output | 1 | Management transaction is a read |
| mdioPhyReg | output | 10 | PHY and register address |
| mdioWrData | output | 16 | Management write data |
| mdioRdData | input | 16 | Management read result, valid with acknowledge |
| mdioAck | input | 1 | Management transaction complete |

## Verification
The hardest situation to reach is a collision on the event register: a software clear and a DMA pulse on the same bit in the same cycle. A request acknowledge that lands in the cycle after a second management write is similarly hard. The bench drives the event pulse and the clearing write on the same negative edge so that both reach one rising edge. It also issues a management write while a request is still pending and checks that the outstanding request's address and data are unchanged before it acknowledges.

// File: rtl/ethmac_regbank_pkg.sv
package ethmac_regbank_pkg;

  localparam int IDX_EVT    = 1;
  localparam int IDX_MASK   = 2;
  localparam int IDX_RXACT  = 4;
  localparam int IDX_TXACT  = 5;
  localparam int IDX_CTRL   = 9;
  localparam int IDX_MGMT   = 16;
  localparam int IDX_MDC    = 17;
  localparam int IDX_MIB    = 25;
  localparam int IDX_RXCTL  = 33;
  localparam int IDX_TXCTL  = 49;
  localparam int IDX_OPCODE = 59;
  localparam int IDX_WMARK  = 81;
  localparam int IDX_FBOUND = 83;
  localparam int IDX_FSTART = 84;
  localparam int IDX_RXBASE = 96;
  localparam int IDX_TXBASE = 97;
  localparam int IDX_BUFMAX = 98;
  localparam int IDX_GCFG   = 192;
  localparam int IDX_GEN    = 194;

  localparam logic [31:0] EVT_IMPL  = 32'hFF80_0000;
  localparam int          EVT_GSTOP = 28;
  localparam int          EVT_MII   = 23;
  localparam int          ACT_BIT   = 24;
  localparam int          MGMT_RD   = 29;

  localparam logic [31:0] FBOUND_VAL = 32'h0000_0600;

  typedef struct packed {
    logic [31:0] evt;
    logic [31:0] ienMask;
    logic [31:0] ctrl;
    logic [31:0] mgmt;
    logic [31:0] mdc;
    logic [31:0] mib;
    logic [31:0] rxCtl;
    logic [31:0] txCtl;
    logic [31:0] opcode;
    logic [31:0] wmark;
    logic [31:0] fstart;
    logic [31:0] rxBase;
    logic [31:0] txBase;
    logic [31:0] bufMax;
    logic [31:0] gcfg;
    logic [31:0] gen;
    logic        rxAct;
    logic        txAct;
  } regs_t;

  localparam regs_t REGS_RST = '{
    evt:     32'h0,
    ienMask: 32'h0,
    ctrl:    32'hF000_0000,
    mgmt:    32'h0,
    mdc:     32'h0,
    mib:     32'hC000_0000,
    rxCtl:   32'h05EE_0001,
    txCtl:   32'h0,
    opcode:  32'h0001_0000,
    wmark:   32'h0,
    fstart:  32'h0000_0500,
    rxBase:  32'h0,
    txBase:  32'h0,
    bufMax:  32'h0,
    gcfg:    32'h0,
    gen:     32'h0000_0006,
    rxAct:   1'b0,
    txAct:   1'b0
  };

  typedef struct packed {
    logic softRst;
    logic evtClr;
    logic maskWr;
    logic rxActWr;
    logic txActWr;
    logic ctrlWr;
    logic macOff;
    logic mgmtWr;
    logic mgmtDone;
    logic mdcWr;
    logic mibWr;
    logic rxCtlWr;
    logic txCtlWr;
    logic opWr;
    logic wmWr;
    logic fstartWr;
    logic rxBaseWr;
    logic txBaseWr;
    logic bufMaxWr;
    logic gcfgWr;
    logic genWr;
  } strobe_t;

endpackage

// File: rtl/ethmac_regbank_ctrl.sv
module ethmac_regbank_ctrl
  import ethmac_regbank_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  input  logic              mdioAck,
  output strobe_t           stb,
  output logic              mdioBusy
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  assign idx = addr[ADDR_W-1:2];

  always_comb begin
    stb = '0;
    if (wrEn) begin
      case (idx)
        IDX_W'(IDX_EVT):    stb.evtClr   = 1'b1;
        IDX_W'(IDX_MASK):   stb.maskWr   = 1'b1;
        IDX_W'(IDX_RXACT):  stb.rxActWr  = 1'b1;
        IDX_W'(IDX_TXACT):  stb.txActWr  = 1'b1;
        IDX_W'(IDX_CTRL): begin
          if (wrData[0]) begin
            stb.softRst = 1'b1;
          end else begin
            stb.ctrlWr = 1'b1;
            stb.macOff = !wrData[1];
          end
        end
        IDX_W'(IDX_MGMT):   stb.mgmtWr   = !mdioBusy;
        IDX_W'(IDX_MDC):    stb.mdcWr    = 1'b1;
        IDX_W'(IDX_MIB):    stb.mibWr    = 1'b1;
        IDX_W'(IDX_RXCTL):  stb.rxCtlWr  = 1'b1;
        IDX_W'(IDX_TXCTL):  stb.txCtlWr  = 1'b1;
        IDX_W'(IDX_OPCODE): stb.opWr     = 1'b1;
        IDX_W'(IDX_WMARK):  stb.wmWr     = 1'b1;
        IDX_W'(IDX_FSTART): stb.fstartWr = 1'b1;
        IDX_W'(IDX_RXBASE): stb.rxBaseWr = 1'b1;
        IDX_W'(IDX_TXBASE): stb.txBaseWr = 1'b1;
        IDX_W'(IDX_BUFMAX): stb.bufMaxWr = 1'b1;
        IDX_W'(IDX_GCFG):   stb.gcfgWr   = 1'b1;
        IDX_W'(IDX_GEN):    stb.genWr    = 1'b1;
        default: ;
      endcase
    end
    stb.mgmtDone = mdioBusy && mdioAck && !stb.softRst;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mdioBusy <= 1'b0;
    end else if (stb.softRst) begin
      mdioBusy <= 1'b0;
    end else if (stb.mgmtWr) begin
      mdioBusy <= 1'b1;
    end else if (stb.mgmtDone) begin
      mdioBusy <= 1'b0;
    end
  end

endmodule

// File: rtl/ethmac_regbank_dp.sv
module ethmac_regbank_dp
  import ethmac_regbank_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  input  logic [31:0]       evtIn,
  input  logic [15:0]       mdioRdData,
  output logic [31:0]       rdData,
  output regs_t             q,
  output logic              irq,
  output logic              rxReload,
  output logic              txReload
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  regs_t            d;
  logic [31:0]      clrBits;
  logic [31:0]      setBits;

  assign idx = addr[ADDR_W-1:2];

  always_comb begin
    clrBits = stb.evtClr ? wrData : '0;
    setBits = evtIn;
    if (stb.txCtlWr && wrData[0]) setBits[EVT_GSTOP] = 1'b1;
    if (stb.mgmtDone)             setBits[EVT_MII]   = 1'b1;
  end

  always_comb begin
    d     = q;
    d.evt = ((q.evt & ~clrBits) | setBits) & EVT_IMPL;
    if (stb.maskWr) d.ienMask = wrData;
    if (stb.ctrlWr) begin
      d.ctrl = wrData;
      if (stb.macOff) begin
        d.rxAct = 1'b0;
        d.txAct = 1'b0;
      end
    end
    if (stb.rxActWr) d.rxAct = q.ctrl[1];
    if (stb.txActWr) d.txAct = q.ctrl[1];
    if (stb.mgmtWr) d.mgmt = wrData;
    if (stb.mgmtDone && q.mgmt[MGMT_RD]) d.mgmt[15:0] = mdioRdData;
    if (stb.mdcWr)    d.mdc    = wrData & 32'h0000_00FE;
    if (stb.mibWr)    d.mib    = wrData[31] ? 32'hC000_0000 : 32'h0;
    if (stb.rxCtlWr)  d.rxCtl  = wrData & 32'h07FF_003F;
    if (stb.txCtlWr)  d.txCtl  = wrData;
    if (stb.opWr)     d.opcode = (wrData & 32'h0000_FFFF) | 32'h0001_0000;
    if (stb.wmWr)     d.wmark  = wrData & 32'h0000_0003;
    if (stb.fstartWr) d.fstart = (wrData & 32'h0000_03FC) | 32'h0000_0400;
    if (stb.rxBaseWr) d.rxBase = wrData & ~32'h3;
    if (stb.txBaseWr) d.txBase = wrData & ~32'h3;
    if (stb.bufMaxWr) d.bufMax = wrData & 32'h0000_07F0;
    if (stb.gcfgWr)   d.gcfg   = wrData & 32'h0000_0053;
    if (stb.genWr)    d.gen    = wrData[1] ? 32'h0000_0006 : 32'h0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q        <= REGS_RST;
      rxReload <= 1'b0;
      txReload <= 1'b0;
    end else if (stb.softRst) begin
      q        <= REGS_RST;
      rxReload <= 1'b1;
      txReload <= 1'b1;
    end else begin
      q        <= d;
      rxReload <= stb.macOff || stb.rxBaseWr;
      txReload <= stb.macOff || stb.txBaseWr;
    end
  end

  assign irq = |(q.evt & q.ienMask);

  always_comb begin
    case (idx)
      IDX_W'(IDX_EVT):    rdData = q.evt;
      IDX_W'(IDX_MASK):   rdData = q.ienMask;
      IDX_W'(IDX_RXACT):  rdData = 32'(q.rxAct) << ACT_BIT;
      IDX_W'(IDX_TXACT):  rdData = 32'(q.txAct) << ACT_BIT;
      IDX_W'(IDX_CTRL):   rdData = q.ctrl;
      IDX_W'(IDX_MGMT):   rdData = q.mgmt;
      IDX_W'(IDX_MDC):    rdData = q.mdc;
      IDX_W'(IDX_MIB):    rdData = q.mib;
      IDX_W'(IDX_RXCTL):  rdData = q.rxCtl;
      IDX_W'(IDX_TXCTL):  rdData = q.txCtl;
      IDX_W'(IDX_OPCODE): rdData = q.opcode;
      IDX_W'(IDX_WMARK):  rdData = q.wmark;
      IDX_W'(IDX_FBOUND): rdData = FBOUND_VAL;
      IDX_W'(IDX_FSTART): rdData = q.fstart;
      IDX_W'(IDX_RXBASE): rdData = q.rxBase;
      IDX_W'(IDX_TXBASE): rdData = q.txBase;
      IDX_W'(IDX_BUFMAX): rdData = q.bufMax;
      IDX_W'(IDX_GCFG):   rdData = q.gcfg;
      IDX_W'(IDX_GEN):    rdData = q.gen;
      default:            rdData = 32'h0;
    endcase
  end

endmodule

// File: rtl/ethmac_regbank.sv
module ethmac_regbank
  import ethmac_regbank_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic [31:0]       evtIn,
  output logic              irq,
  output logic              macEnable,
  output logic              rxActive,
  output logic              txActive,
  output logic [31:0]       rxRingBase,
  output logic [31:0]       txRingBase,
  output logic              rxPtrReload,
  output logic              txPtrReload,
  output logic              mdioReq,
  output logic              mdioRead,
  output logic [9:0]        mdioPhyReg,
  output logic [15:0]       mdioWrData,
  input  logic [15:0]       mdioRdData,
  input  logic              mdioAck
);
  strobe_t     stb;
  regs_t       regQ;
  logic        mdioBusy;
  logic [31:0] evtQ;
  logic [31:0] maskQ;

  ethmac_regbank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .addr     (addr),
    .wrData   (wrData),
    .mdioAck  (mdioAck),
    .stb      (stb),
    .mdioBusy (mdioBusy)
  );

  ethmac_regbank_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .addr       (addr),
    .wrData     (wrData),
    .evtIn      (evtIn),
    .mdioRdData (mdioRdData),
    .rdData     (rdData),
    .q          (regQ),
    .irq        (irq),
    .rxReload   (rxPtrReload),
    .txReload   (txPtrReload)
  );

  assign evtQ       = regQ.evt;
  assign maskQ      = regQ.ienMask;
  assign macEnable  = regQ.ctrl[1];
  assign rxActive   = regQ.rxAct;
  assign txActive   = regQ.txAct;
  assign rxRingBase = regQ.rxBase;
  assign txRingBase = regQ.txBase;
  assign mdioReq    = mdioBusy;
  assign mdioRead   = regQ.mgmt[MGMT_RD];
  assign mdioPhyReg = regQ.mgmt[27:18];
  assign mdioWrData = regQ.mgmt[15:0];

endmodule

// File: rtl/ethmac_regbank_chk.sv
module ethmac_regbank_chk
  import ethmac_regbank_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic [31:0]       evtIn,
  input logic [31:0]       evtQ,
  input logic [31:0]       maskQ,
  input logic              irq,
  input logic              rxActive,
  input logic              txActive,
  input logic              rxPtrReload,
  input logic              txPtrReload,
  input logic              mdioReq,
  input logic              mdioAck
);
  localparam int IDX_W = ADDR_W - 2;
  logic [IDX_W-1:0] idx;
  logic             srstWr;
  assign idx    = addr[ADDR_W-1:2];
  assign srstWr = wrEn && idx == IDX_W'(IDX_CTRL) && wrData[0];

  // R3
  evt_w1c_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && idx == IDX_W'(IDX_EVT) && evtIn == 32'h0 && !(mdioReq && mdioAck)
    |=> (evtQ & $past(wrData)) == 32'h0);

  // R4
  evt_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn & EVT_IMPL) != 32'h0 && !srstWr
    |=> (evtQ & $past(evtIn & EVT_IMPL)) == $past(evtIn & EVT_IMPL));

  // R5
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    maskQ == 32'h0 |-> !irq);

  // R9
  mac_off_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && idx == IDX_W'(IDX_CTRL) && !wrData[0] && !wrData[1]
    |=> rxPtrReload && txPtrReload && !rxActive && !txActive);

  // R13
  mdio_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    mdioReq && !mdioAck && !srstWr |=> mdioReq);

  // R13
  mdio_done_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    mdioReq && mdioAck && !srstWr |=> evtQ[EVT_MII] && !mdioReq);

endmodule

bind ethmac_regbank ethmac_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .addr        (addr),
  .wrData      (wrData),
  .evtIn       (evtIn),
  .evtQ        (evtQ),
  .maskQ       (maskQ),
  .irq         (irq),
  .rxActive    (rxActive),
  .txActive    (txActive),
  .rxPtrReload (rxPtrReload),
  .txPtrReload (txPtrReload),
  .mdioReq     (mdioReq),
  .mdioAck     (mdioAck)
);

// File: tb/ethmac_regbank_bench.sv
module ethmac_regbank_bench;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic [31:0]   evtIn = '0;
  logic          irq, macEnable, rxActive, txActive, rxPtrReload, txPtrReload;
  logic [31:0]   rxRingBase, txRingBase;
  logic          mdioReq, mdioRead, mdioAck = 1'b0;
  logic [9:0]    mdioPhyReg;
  logic [15:0]   mdioWrData, mdioRdData = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ethmac_regbank #(.ADDR_W(AW)) u_ethmac_regbank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .evtIn(evtIn), .irq(irq), .macEnable(macEnable),
    .rxActive(rxActive), .txActive(txActive), .rxRingBase(rxRingBase),
    .txRingBase(txRingBase), .rxPtrReload(rxPtrReload),
    .txPtrReload(txPtrReload), .mdioReq(mdioReq), .mdioRead(mdioRead),
    .mdioPhyReg(mdioPhyReg), .mdioWrData(mdioWrData),
    .mdioRdData(mdioRdData), .mdioAck(mdioAck)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [31:0] val);
    @(negedge clk);
    wrEn = 1'b1; addr = AW'(idx * 4); wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(string req, int idx, logic [31:0] exp);
    addr = AW'(idx * 4);
    #0.5;
    check(req, rdData, exp);
  endtask

  task automatic t_reset;
    rdChk("R2 ctrl", 9, 32'hF000_0000);
    rdChk("R2 mib", 25, 32'hC000_0000);
    rdChk("R2 rxctl", 33, 32'h05EE_0001);
    rdChk("R2 opcode", 59, 32'h0001_0000);
    rdChk("R2 fbound", 83, 32'h600);
    rdChk("R2 fstart", 84, 32'h500);
    rdChk("R2 gen", 194, 32'h6);
    rdChk("R2 evt", 1, 32'h0);
    check("R2 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_masks;
    wr(33, '1);  rdChk("R6 rxctl", 33, 32'h07FF_003F);
    wr(17, '1);  rdChk("R6 mdc", 17, 32'hFE);
    wr(81, '1);  rdChk("R6 wmark", 81, 32'h3);
    wr(98, '1);  rdChk("R6 bufmax", 98, 32'h7F0);
    wr(192, '1); rdChk("R6 gcfg", 192, 32'h53);
  endtask

  task automatic t_forced;
    wr(84, '1);               rdChk("R7 fstart ones", 84, 32'h7FC);
    wr(84, 32'h0);            rdChk("R7 fstart zero", 84, 32'h400);
    wr(59, 32'h1234_5678);    rdChk("R7 opcode", 59, 32'h0001_5678);
    wr(25, 32'h7FFF_FFFF);    rdChk("R7 mib clear", 25, 32'h0);
    wr(25, 32'h8000_0000);    rdChk("R7 mib set", 25, 32'hC000_0000);
    wr(194, 32'hFFFF_FFFD);   rdChk("R7 gen clear", 194, 32'h0);
    wr(194, 32'h2);           rdChk("R7 gen set", 194, 32'h6);
  endtask

  task automatic t_unimpl;
    wr(83, 32'h0);            rdChk("R12 fbound ro", 83, 32'h600);
    wr(70, 32'hFFFF_FFFF);    rdChk("R1 unimpl", 70, 32'h0);
    rdChk("R1 index shift", 33, 32'h07FF_003F);
  endtask

  task automatic t_events;
    @(negedge clk); evtIn = 32'hFFFF_FFFF;
    @(negedge clk); evtIn = 32'h0;
    rdChk("R3 impl bits", 1, 32'hFF80_0000);
    wr(1, 32'h0C00_0000);     rdChk("R3 w1c", 1, 32'hF380_0000);
    @(negedge clk);
    wrEn = 1'b1; addr = AW'(4); wrData = 32'hFF80_0000; evtIn = 32'h0800_0000;
    @(negedge clk);
    wrEn = 1'b0; evtIn = 32'h0;
    rdChk("R4 set wins", 1, 32'h0800_0000);
    check("R5 irq masked", 32'(irq), 32'h0);
    wr(2, 32'h0800_0000);
    check("R5 irq high", 32'(irq), 32'h1);
    wr(1, 32'h0800_0000);
    check("R5 irq low", 32'(irq), 32'h0);
    wr(49, 32'h1);            rdChk("R12 gstop evt", 1, 32'h1000_0000);
    wr(1, '1);
  endtask

  task automatic t_mgmt;
    wr(16, 32'h2000_0000 | (32'h155 << 18) | 32'h0000_1111);
    check("R13 req", 32'(mdioReq), 32'h1);
    check("R13 read", 32'(mdioRead), 32'h1);
    check("R13 addr", 32'(mdioPhyReg), 32'h155);
    @(negedge clk); mdioAck = 1'b1; mdioRdData = 16'hBEEF;
    @(negedge clk); mdioAck = 1'b0;
    check("R13 req drop", 32'(mdioReq), 32'h0);
    rdChk("R13 deposit", 16, 32'h2000_0000 | (32'h155 << 18) | 32'hBEEF);
    rdChk("R13 evt", 1, 32'h0080_0000);
    wr(1, '1);
    wr(16, (32'h0AA << 18) | 32'h0000_1234);
    wr(16, 32'h2000_5678);
    check("R13 busy ignore", 32'(mdioWrData), 32'h1234);
    check("R13 write op", 32'(mdioRead), 32'h0);
    @(negedge clk); mdioAck = 1'b1; mdioRdData = 16'hDEAD;
    @(negedge clk); mdioAck = 1'b0;
    rdChk("R13 write kept", 16, (32'h0AA << 18) | 32'h1234);
    rdChk("R13 write evt", 1, 32'h0080_0000);
    wr(1, '1);
  endtask

  task automatic t_enable;
    wr(4, 32'h0);             rdChk("R10 rx off", 4, 32'h0);
    wr(9, 32'h2);
    check("R9 enable", 32'(macEnable), 32'h1);
    wr(4, 32'h0);             rdChk("R10 rx on", 4, 32'h0100_0000);
    wr(5, 32'h0);             rdChk("R10 tx on", 5, 32'h0100_0000);
    wr(9, 32'h0);
    check("R9 rx reload", 32'(rxPtrReload), 32'h1);
    check("R9 tx reload", 32'(txPtrReload), 32'h1);
    rdChk("R9 rx cleared", 4, 32'h0);
    rdChk("R9 tx cleared", 5, 32'h0);
    wr(96, 32'h0000_1003);
    check("R11 rx reload", 32'(rxPtrReload), 32'h1);
    check("R11 tx quiet", 32'(txPtrReload), 32'h0);
    check("R11 rx base", rxRingBase, 32'h0000_1000);
    wr(97, 32'h0000_2002);
    check("R11 tx reload", 32'(txPtrReload), 32'h1);
    check("R11 tx base", txRingBase, 32'h0000_2000);
  endtask

  task automatic t_softrst;
    wr(2, 32'hFF80_0000);
    wr(33, 32'h0);
    @(negedge clk); evtIn = 32'h8000_0000;
    @(negedge clk); evtIn = 32'h0;
    wr(9, 32'h3);
    check("R8 reload", 32'(rxPtrReload & txPtrReload), 32'h1);
    rdChk("R8 ctrl", 9, 32'hF000_0000);
    rdChk("R8 mask", 2, 32'h0);
    rdChk("R8 evt", 1, 32'h0);
    rdChk("R8 rxctl", 33, 32'h05EE_0001);
    check("R8 rxbase", rxRingBase, 32'h0);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_masks();
    t_forced();
    t_unimpl();
    t_events();
    t_mgmt();
    t_enable();
    t_softrst();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule